// File: doc/BRIEF.md
# Flash Program Unlock Sequence Decoder

This block sits between a host bus front end and the controller of a byte-wide flash array. Every accepted bus write reaches it as a one-cycle strobe with a 20-bit byte address and an 8-bit data byte. The decoder watches for a fixed three-write command prefix and, once the prefix is complete, treats the next write as the target of a byte program. It then raises a one-cycle program request that carries that write's address and data.

The prefix is checked step by step. A write that breaks the order sends the decoder back to its start, unless that write is itself a valid first step. The reset byte F0 clears any partial sequence, whatever the address. After a program request the block models the array's internal programming time with a down-counter. While that counter runs it holds a busy output high and discards every write.

Top module: `prog_unlock_decoder`

## Requirements
- R1: After reset the program request and busy are low, the program address and data read zero, and the decoder waits for the first prefix step.
- R2: From the start state, or after any partial prefix, a write of data 0xAA whose low address bits equal 0x5555 completes the first prefix step.
- R3: With the first step complete, a write of data 0x55 whose low address bits equal 0x2AAA completes the second prefix step.
- R4: With the second step complete, a write of data 0xA0 whose low address bits equal 0x5555 completes the third step and arms the decoder.
- R5: When the decoder is armed, the next write (unless it carries 0xF0) raises prog_req for exactly one cycle, starting in the cycle after the write. prog_addr and prog_data then show that write's full address and data, and the decoder returns to its start state.
- R6: Prefix address comparisons use only address bits 14:0. Bits 19:15 are ignored.
- R7: A write that does not match the expected prefix step returns the decoder to its start state. The exception is a write of 0xAA to 0x5555, which counts as a completed first step.
- R8: A write of data 0xF0, to any address and at any step including the armed state, returns the decoder to its start state without a program request.
- R9: busy goes high in the same cycle as prog_req and stays high for exactly BUSY_CYCLES cycles.
- R10: Writes presented while busy is high have no effect on the sequence state and never cause a program request.
- R11: prog_addr and prog_data keep their values until the next program request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 20 | Write byte address |
| wr_data | input | 8 | Write data byte |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 20 | Address of the byte to program |
| prog_data | output | 8 | Byte to program |
| busy | output | 1 | Programming in progress; writes ignored |

## Verification
Every result here is registered once. A write sampled at a rising edge shows its program request, captured address and data, and the rise of busy right after that edge, and busy falls BUSY_CYCLES edges later. The bench drives each write on the falling edge and updates its own cycle model after the next rising edge. It compares all outputs 1 ns after that edge, so every check lands in the cycle where the result first becomes due. Changes in the prefix state show up only through later requests, which is why the directed cases follow each disturbance with a target write and check whether a request appears.

// File: rtl/prog_unlock_pkg.sv
`timescale 1ns/1ps
package prog_unlock_pkg;

  localparam int CMP_W = 15;
  localparam int KEY_W = 8;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [KEY_W-1:0] KEY_DATA_1 = 8'hAA;
  localparam logic [KEY_W-1:0] KEY_DATA_2 = 8'h55;
  localparam logic [KEY_W-1:0] KEY_DATA_3 = 8'hA0;
  localparam logic [KEY_W-1:0] KEY_ABORT  = 8'hF0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_UNL1  = 2'd1,
    ST_UNL2  = 2'd2,
    ST_ARMED = 2'd3
  } seq_state_t;

  function automatic logic key_hit(input logic [CMP_W-1:0] a_low,
                                   input logic [KEY_W-1:0] d,
                                   input logic [CMP_W-1:0] k_addr,
                                   input logic [KEY_W-1:0] k_data);
    return (a_low == k_addr) && (d == k_data);
  endfunction

  function automatic seq_state_t step_next(input seq_state_t cur,
                                           input logic h1, input logic h2,
                                           input logic h3, input logic ab);
    seq_state_t nx;
    nx = ST_IDLE;
    if (!ab) begin
      unique case (cur)
        ST_UNL1: nx = h2 ? ST_UNL2  : (h1 ? ST_UNL1 : ST_IDLE);
        ST_UNL2: nx = h3 ? ST_ARMED : (h1 ? ST_UNL1 : ST_IDLE);
        default: nx = h1 ? ST_UNL1  : ST_IDLE;
      endcase
    end
    return nx;
  endfunction

endpackage

// File: rtl/pud_cmd_match.sv
`timescale 1ns/1ps
module pud_cmd_match
  import prog_unlock_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              hit_first,
  output logic              hit_second,
  output logic              hit_third,
  output logic              abort
);

  logic [CMP_W-1:0] addr_low;
  logic [KEY_W-1:0] data_key;

  assign addr_low   = wr_addr[CMP_W-1:0];
  assign data_key   = wr_data[KEY_W-1:0];

  assign hit_first  = key_hit(addr_low, data_key, KEY_ADDR_A, KEY_DATA_1);
  assign hit_second = key_hit(addr_low, data_key, KEY_ADDR_B, KEY_DATA_2);
  assign hit_third  = key_hit(addr_low, data_key, KEY_ADDR_A, KEY_DATA_3);
  assign abort      = (data_key == KEY_ABORT);

endmodule

// File: rtl/pud_seq_fsm.sv
`timescale 1ns/1ps
module pud_seq_fsm
  import prog_unlock_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_accept,
  input  logic              hit_first,
  input  logic              hit_second,
  input  logic              hit_third,
  input  logic              abort,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              issue,
  output seq_state_t        state,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);

  seq_state_t state_nx;

  assign issue = wr_accept && !abort && (state == ST_ARMED);

  always_comb begin
    state_nx = state;
    if (wr_accept)
      state_nx = (state == ST_ARMED) ? ST_IDLE
                 : step_next(state, hit_first, hit_second, hit_third, abort);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      prog_req  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      state    <= state_nx;
      prog_req <= issue;
      if (issue) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && hit_first && state != ST_ARMED |=> state == ST_UNL1); // R2
  AST_STEP_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && hit_second && state == ST_UNL1 |=> state == ST_UNL2); // R3
  AST_STEP_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && hit_third && state == ST_UNL2 |=> state == ST_ARMED); // R4
  AST_REQ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> prog_addr == $past(wr_addr) && prog_data == $past(wr_data)); // R5
  AST_MISMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && state == ST_IDLE && !hit_first |=> state == ST_IDLE); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && abort |=> state == ST_IDLE && !prog_req); // R8

endmodule

// File: rtl/pud_busy_timer.sv
`timescale 1ns/1ps
module pud_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= LOAD_VAL;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R10
  AST_LOAD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R9

endmodule

// File: rtl/prog_unlock_decoder.sv
`timescale 1ns/1ps
module prog_unlock_decoder
  import prog_unlock_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              busy
);

  logic       hit_first, hit_second, hit_third, abort;
  logic       wr_accept, issue;
  seq_state_t state;

  assign wr_accept = wr_en && !busy;

  pud_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .hit_third (hit_third),
    .abort     (abort)
  );

  pud_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .hit_first (hit_first),
    .hit_second(hit_second),
    .hit_third (hit_third),
    .abort     (abort),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .issue     (issue),
    .state     (state),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data)
  );

  pud_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (issue),
    .busy (busy)
  );

  AST_REQ_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> busy); // R9
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req); // R5
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> !prog_req && $stable(state)); // R10
  AST_HOLD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_req |-> $stable(prog_addr) && $stable(prog_data)); // R11

endmodule

// File: tb/prog_unlock_decoder_test.sv
`timescale 1ns/1ps
module prog_unlock_decoder_test;

  localparam int B = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_req, busy;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;

  int errors = 0;
  int checks = 0;

  int          m_step = 0;
  int          m_cnt  = 0;
  logic        m_req  = 1'b0;
  logic [19:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  int          req_seen = 0;

  always #2.5 clk = ~clk;

  prog_unlock_decoder #(.ADDR_W(20), .DATA_W(8), .BUSY_CYCLES(B)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .busy(busy)
  );

  function automatic int exp_step(input int s, input logic [19:0] a, input logic [7:0] d);
    logic first;
    first = (a[14:0] == 15'h5555) && (d == 8'hAA);
    if (s == 1 && a[14:0] == 15'h2AAA && d == 8'h55) return 2;
    if (s == 2 && a[14:0] == 15'h5555 && d == 8'hA0) return 3;
    return first ? 1 : 0;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input logic en, input logic [19:0] a, input logic [7:0] d);
    m_req = 1'b0;
    if (en && m_cnt == 0) begin
      if (d == 8'hF0) m_step = 0;
      else if (m_step == 3) begin
        m_req = 1'b1; m_addr = a; m_data = d; m_step = 0; m_cnt = B;
      end else m_step = exp_step(m_step, a, d);
    end else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic cycle(input logic en, input logic [19:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(en, a, d);
    #1;
    if (prog_req) req_seen++;
    check(prog_req == m_req, tag, 32'(prog_req), 32'(m_req));
    check(busy == (m_cnt != 0), "R9 R10 busy", 32'(busy), 32'(m_cnt != 0));
    check(prog_addr == m_addr, "R5 R11 addr", 32'(prog_addr), 32'(m_addr));
    check(prog_data == m_data, "R5 R11 data", 32'(prog_data), 32'(m_data));
  endtask

  task automatic wr(input logic [19:0] a, input logic [7:0] d, input string tag);
    cycle(1'b1, a, d, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b0, 20'h0, 8'h0, tag);
  endtask

  task automatic unlock(input logic [19:0] hi, input string tag);
    wr(hi | 20'h05555, 8'hAA, tag);
    wr(hi | 20'h02AAA, 8'h55, tag);
    wr(hi | 20'h05555, 8'hA0, tag);
  endtask

  initial begin
    int r;
    r = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(prog_req == 1'b0 && busy == 1'b0, "R1 reset outputs", {prog_req, busy}, 0);
    check(prog_addr == 0 && prog_data == 0, "R1 reset target", {prog_addr, prog_data}, 0);

    // R2 R3 R4 R5: plain sequence then target
    req_seen = 0;
    unlock(20'h0, "R2 R3 R4");
    wr(20'h12345, 8'h3C, "R5 request");
    idle(B + 2, "R9 busy window");
    check(req_seen == 1, "R5 one request", req_seen, 1);

    // R6: upper address bits differ in every prefix write
    req_seen = 0;
    wr(20'hF5555, 8'hAA, "R6"); wr(20'h8AAAA, 8'h55, "R6"); wr(20'h3D555, 8'hA0, "R6");
    wr(20'hABCDE, 8'h81, "R6 request");
    idle(B, "R6");
    check(req_seen == 1, "R6 upper bits ignored", req_seen, 1);

    // R7: broken prefix, then restart by AA/5555 inside prefix
    req_seen = 0;
    wr(20'h05555, 8'hAA, "R7"); wr(20'h02AAA, 8'h55, "R7"); wr(20'h01234, 8'h00, "R7");
    wr(20'h05555, 8'hA0, "R7"); wr(20'h00042, 8'h11, "R7 no request");
    check(req_seen == 0, "R7 mismatch to idle", req_seen, 0);
    wr(20'h05555, 8'hAA, "R7"); wr(20'h05555, 8'hAA, "R7");
    wr(20'h02AAA, 8'h55, "R7"); wr(20'h05555, 8'hA0, "R7");
    wr(20'h00077, 8'h22, "R7 request");
    idle(B, "R7");
    check(req_seen == 1, "R7 AA restarts step one", req_seen, 1);

    // R8: F0 while armed and mid-prefix
    req_seen = 0;
    unlock(20'h0, "R8"); wr(20'h99999, 8'hF0, "R8"); wr(20'h00100, 8'h33, "R8 no request");
    wr(20'h05555, 8'hAA, "R8"); wr(20'h00000, 8'hF0, "R8");
    wr(20'h02AAA, 8'h55, "R8"); wr(20'h05555, 8'hA0, "R8"); wr(20'h00101, 8'h34, "R8 no request");
    check(req_seen == 0, "R8 abort", req_seen, 0);

    // R10: prefix written during busy is discarded
    req_seen = 0;
    unlock(20'h0, "R10"); wr(20'h00200, 8'h44, "R10 request");
    unlock(20'h0, "R10 ignored");
    idle(B, "R10");
    wr(20'h00201, 8'h45, "R10 no request");
    check(req_seen == 1, "R10 writes during busy ignored", req_seen, 1);
    idle(2, "R11");
    check(prog_addr == 20'h00200 && prog_data == 8'h44, "R11 hold",
          {prog_addr, prog_data}, {20'h00200, 8'h44});

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int kind;
      kind = int'($urandom % 8);
      if (kind < 3) begin
        for (int s = 0; s < 4; s++) begin
          logic [19:0] a; logic [7:0] d;
          a = {$urandom} [19:0]; d = {$urandom} [7:0];
          if (s == 0) begin a[14:0] = 15'h5555; d = 8'hAA; end
          if (s == 1) begin a[14:0] = 15'h2AAA; d = 8'h55; end
          if (s == 2) begin a[14:0] = 15'h5555; d = 8'hA0; end
          if ($urandom % 7 == 0) d = {$urandom} [7:0];
          wr(a, d, "R5 R7 random");
          if ($urandom % 3 == 0) idle(1, "R5 random gap");
        end
      end else if (kind == 3) wr({$urandom} [19:0], 8'hF0, "R8 random");
      else if (kind < 6) wr({$urandom} [19:0], {$urandom} [7:0], "R7 random");
      else idle(int'($urandom % 4) + 1, "R9 random idle");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule